// File: doc/BRIEF.md
# 16x16 Luma Intra Predictor

This block builds a 16x16 block of predicted luma samples from the already reconstructed samples that surround it: sixteen samples in the row above, sixteen in the column to the left, and the single sample at the upper-left corner. A request carries those neighbours and a 2-bit mode. The block latches everything on the request, then emits the prediction one 128-bit row per clock.

Four modes exist. Vertical copies the upper row down. Horizontal spreads each left sample across its row. DC fills the block with the rounded mean of all 32 edge samples. Plane fits a linear gradient across the block. For plane mode the gradient terms are formed once, in a setup cycle. After that one adder per column advances a running accumulator by the vertical slope for each new row. A saturating stage clamps every column into the 8-bit range.

Top module: `luma16_intra_pred`

## Requirements
- R1: After reset `busy_o`, `row_valid_o` and `done_o` are all low.
- R2: Mode code 0 (vertical) yields every row equal to `top_i`.
- R3: Mode code 1 (horizontal) yields row y with all sixteen columns equal to left sample y, where sample k of a neighbour vector sits in bits [8k+7:8k].
- R4: Mode code 2 (DC) fills the block with (sum of the 16 upper and 16 left samples + 16) >> 5.
- R5: Mode code 3 (plane) computes sample (x,y) as clamp(0..255, (a + b*(x-7) + c*(y-7) + 16) >>> 5). Here a = 16*(top[15]+left[15]), b = (5*H+32) >>> 6 and c = (5*V+32) >>> 6. H sums (k+1)*(top[8+k] - top[6-k]) for k = 0..7, with top[-1] taken as the corner sample. V is formed the same way from the left column.
- R6: Plane results below 0 come out as 0 and results above 255 come out as 255, with no wrap-around for steep gradients.
- R7: A `start_i` seen while `busy_o` is high is ignored, and changing the neighbour or mode inputs after acceptance does not alter the rows of the request in progress.
- R8: The first row appears two clocks after the accepting edge. Sixteen rows follow on consecutive cycles with `row_idx_o` counting 0 to 15. `done_o` is high only together with row 15.
- R9: Column x of an output row occupies bits [8x+7:8x] of `row_o`, so column 0 is the least significant byte.
- R10: `busy_o` rises on the clock after acceptance and stays high until the edge that presents row 15. A new request can be accepted in the cycle that shows row 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; accepted when `busy_o` is low |
| mode_i | input | 2 | 0 vertical, 1 horizontal, 2 DC, 3 plane |
| top_i | input | 128 | Upper neighbours, sample k in bits [8k+7:8k] |
| left_i | input | 128 | Left neighbours, sample k in bits [8k+7:8k] |
| corner_i | input | 8 | Upper-left corner sample |
| busy_o | output | 1 | Request in progress |
| row_valid_o | output | 1 | `row_o` holds a prediction row |
| row_idx_o | output | 4 | Row number of `row_o` |
| row_o | output | 128 | Sixteen predicted samples, column 0 in the low byte |
| done_o | output | 1 | High with the last row |

## Verification
In plane mode, a wrong slope or intercept spoils row 0 at once. A wrong per-row increment leaves row 0 intact and the error grows with each row, so it appears by row 1 and is largest at row 15. Every row is compared against an expression evaluated directly for each sample, without any running sum. That means errors that build up across rows are caught as well as errors in setup. A sequencing fault in the row counter or state shows up within one cycle as a skipped or repeated `row_idx_o`, or as `done_o` on the wrong row. Junk requests are pushed while the block is busy, so a latch that is not held shows as corrupted rows during that same request.

// File: rtl/lip_pkg.sv
package lip_pkg;
    localparam int LIP_N     = 16;
    localparam int LIP_HALF  = LIP_N / 2;
    localparam int LIP_CNT_W = $clog2(LIP_N);

    typedef enum logic [1:0] {
        M_VERT  = 2'd0,
        M_HORZ  = 2'd1,
        M_DC    = 2'd2,
        M_PLANE = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SETUP = 2'd1,
        S_EMIT  = 2'd2
    } st_e;
endpackage

// File: rtl/lip_plane_grad.sv
module lip_plane_grad
    import lip_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18
) (
    input  logic [LIP_N*PIX_W-1:0]   top_i,
    input  logic [LIP_N*PIX_W-1:0]   left_i,
    input  logic [PIX_W-1:0]         corner_i,
    output logic signed [ACC_W-1:0]  a_o,
    output logic signed [ACC_W-1:0]  b_o,
    output logic signed [ACC_W-1:0]  c_o,
    output logic [PIX_W-1:0]         dc_o
);
    localparam int DC_SH = $clog2(2 * LIP_N);

    int h_sum, v_sum, e_sum, t_far, l_far, b_v, c_v, a_v;

    always_comb begin
        h_sum = 0;
        v_sum = 0;
        e_sum = 0;
        for (int k = 0; k < LIP_HALF; k++) begin
            if (k == LIP_HALF - 1) begin
                t_far = int'(corner_i);
                l_far = int'(corner_i);
            end else begin
                t_far = int'(top_i[(LIP_HALF-2-k)*PIX_W +: PIX_W]);
                l_far = int'(left_i[(LIP_HALF-2-k)*PIX_W +: PIX_W]);
            end
            h_sum = h_sum + (k + 1) * (int'(top_i[(LIP_HALF+k)*PIX_W +: PIX_W]) - t_far);
            v_sum = v_sum + (k + 1) * (int'(left_i[(LIP_HALF+k)*PIX_W +: PIX_W]) - l_far);
        end
        for (int k = 0; k < LIP_N; k++) begin
            e_sum = e_sum + int'(top_i[k*PIX_W +: PIX_W]) + int'(left_i[k*PIX_W +: PIX_W]);
        end
        b_v = (5 * h_sum + 32) >>> 6;
        c_v = (5 * v_sum + 32) >>> 6;
        a_v = 16 * (int'(top_i[(LIP_N-1)*PIX_W +: PIX_W]) + int'(left_i[(LIP_N-1)*PIX_W +: PIX_W]));
        a_o  = ACC_W'(a_v);
        b_o  = ACC_W'(b_v);
        c_o  = ACC_W'(c_v);
        dc_o = PIX_W'((e_sum + LIP_N) >> DC_SH);
    end
endmodule

// File: rtl/lip_row_sat.sv
module lip_row_sat
    import lip_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18,
    parameter int FRAC  = 5
) (
    input  logic [LIP_N*ACC_W-1:0] acc_i,
    output logic [LIP_N*PIX_W-1:0] row_o
);
    localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

    for (genvar gx = 0; gx < LIP_N; gx++) begin : g_col
        logic signed [ACC_W-1:0] shifted;
        always_comb begin
            shifted = $signed(acc_i[gx*ACC_W +: ACC_W]) >>> FRAC;
            if (shifted < 0)
                row_o[gx*PIX_W +: PIX_W] = '0;
            else if (shifted > PIX_MAX)
                row_o[gx*PIX_W +: PIX_W] = '1;
            else
                row_o[gx*PIX_W +: PIX_W] = shifted[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/luma16_intra_pred.sv
module luma16_intra_pred
    import lip_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [1:0]                 mode_i,
    input  logic [LIP_N*PIX_W-1:0]     top_i,
    input  logic [LIP_N*PIX_W-1:0]     left_i,
    input  logic [PIX_W-1:0]           corner_i,
    output logic                       busy_o,
    output logic                       row_valid_o,
    output logic [LIP_CNT_W-1:0]       row_idx_o,
    output logic [LIP_N*PIX_W-1:0]     row_o,
    output logic                       done_o
);
    localparam int ROW_W = LIP_N * PIX_W;
    localparam int ACC_VEC_W = LIP_N * ACC_W;
    localparam int ROUND = 16;

    typedef struct packed {
        st_e                   st;
        mode_e                 mode;
        logic [ROW_W-1:0]      top;
        logic [ROW_W-1:0]      left;
        logic [PIX_W-1:0]      corner;
        logic [LIP_CNT_W-1:0]  cnt;
        logic [ACC_VEC_W-1:0]  acc;
        logic                  vld;
        logic                  done;
        logic [LIP_CNT_W-1:0]  idx;
        logic [ROW_W-1:0]      row;
    } state_t;

    state_t st_d, st_q;

    logic signed [ACC_W-1:0] a_w, b_w, c_w;
    logic [PIX_W-1:0]        dc_w;
    logic [ROW_W-1:0]        plane_row_w;

    lip_plane_grad #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_grad (
        .top_i    (st_q.top),
        .left_i   (st_q.left),
        .corner_i (st_q.corner),
        .a_o      (a_w),
        .b_o      (b_w),
        .c_o      (c_w),
        .dc_o     (dc_w)
    );

    lip_row_sat #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC(5)) u_sat (
        .acc_i (st_q.acc),
        .row_o (plane_row_w)
    );

    logic signed [ACC_W-1:0] col_off;
    logic signed [ACC_W-1:0] acc_col;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.done = 1'b0;
        col_off   = '0;
        acc_col   = '0;
        unique case (st_q.st)
            S_IDLE: begin
                if (start_i) begin
                    st_d.st     = S_SETUP;
                    st_d.mode   = mode_e'(mode_i);
                    st_d.top    = top_i;
                    st_d.left   = left_i;
                    st_d.corner = corner_i;
                end
            end
            S_SETUP: begin
                for (int x = 0; x < LIP_N; x++) begin
                    col_off = ACC_W'(x) - ACC_W'(LIP_HALF - 1);
                    st_d.acc[x*ACC_W +: ACC_W] = a_w + b_w * col_off
                                               - ACC_W'(LIP_HALF - 1) * c_w + ACC_W'(ROUND);
                end
                st_d.cnt = '0;
                st_d.st  = S_EMIT;
            end
            S_EMIT: begin
                st_d.vld = 1'b1;
                st_d.idx = st_q.cnt;
                unique case (st_q.mode)
                    M_VERT:  st_d.row = st_q.top;
                    M_HORZ:  st_d.row = {LIP_N{st_q.left[st_q.cnt*PIX_W +: PIX_W]}};
                    M_DC:    st_d.row = {LIP_N{dc_w}};
                    default: st_d.row = plane_row_w;
                endcase
                for (int x = 0; x < LIP_N; x++) begin
                    acc_col = $signed(st_q.acc[x*ACC_W +: ACC_W]);
                    st_d.acc[x*ACC_W +: ACC_W] = acc_col + c_w;
                end
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LIP_CNT_W'(LIP_N - 1)) begin
                    st_d.done = 1'b1;
                    st_d.st   = S_IDLE;
                end
            end
            default: st_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o      = (st_q.st != S_IDLE);
    assign row_valid_o = st_q.vld;
    assign row_idx_o   = st_q.idx;
    assign row_o       = st_q.row;
    assign done_o      = st_q.done;
endmodule

// File: rtl/lip_pred_chk.sv
module lip_pred_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             row_valid_o,
    input logic [CNT_W-1:0] row_idx_o,
    input logic             done_o
);
    a_r8_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (row_valid_o && row_idx_o == '1));

    a_r8_rows_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_o && !done_o) |=> (row_valid_o && row_idx_o == CNT_W'($past(row_idx_o) + 1'b1)));

    a_r8_first_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_o && !$past(row_valid_o)) |-> (row_idx_o == '0));

    a_r10_busy_during_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_o && !done_o) |-> busy_o);

    a_r10_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r7_busy_holds_until_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !row_valid_o && $past(busy_o)) |=> busy_o);
endmodule

bind luma16_intra_pred lip_pred_chk #(.CNT_W(lip_pkg::LIP_CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .row_valid_o (row_valid_o),
    .row_idx_o   (row_idx_o),
    .done_o      (done_o)
);

// File: tb/luma16_intra_pred_tb_top.sv
module luma16_intra_pred_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   mode_i = '0;
    logic [127:0] top_i = '0;
    logic [127:0] left_i = '0;
    logic [7:0]   corner_i = '0;
    logic         busy_o, row_valid_o, done_o;
    logic [3:0]   row_idx_o;
    logic [127:0] row_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    luma16_intra_pred dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .top_i(top_i), .left_i(left_i), .corner_i(corner_i),
        .busy_o(busy_o), .row_valid_o(row_valid_o), .row_idx_o(row_idx_o),
        .row_o(row_o), .done_o(done_o)
    );

    function automatic int px(logic [127:0] v, int k);
        return int'(v[8*k +: 8]);
    endfunction

    function automatic logic [7:0] exp_pix(int mode, logic [127:0] t, logic [127:0] l,
                                           logic [7:0] cr, int x, int y);
        int s, h, v, a, b, c, r, tf, lf;
        case (mode)
            0: return t[8*x +: 8];
            1: return l[8*y +: 8];
            2: begin
                s = 0;
                for (int k = 0; k < 16; k++) s += px(t, k) + px(l, k);
                return 8'((s + 16) >> 5);
            end
            default: begin
                h = 0; v = 0;
                for (int k = 0; k < 8; k++) begin
                    tf = (k == 7) ? int'(cr) : px(t, 6 - k);
                    lf = (k == 7) ? int'(cr) : px(l, 6 - k);
                    h += (k + 1) * (px(t, 8 + k) - tf);
                    v += (k + 1) * (px(l, 8 + k) - lf);
                end
                b = (5 * h + 32) >>> 6;
                c = (5 * v + 32) >>> 6;
                a = 16 * (px(t, 15) + px(l, 15));
                r = (a + b * (x - 7) + c * (y - 7) + 16) >>> 5;
                if (r < 0) r = 0;
                if (r > 255) r = 255;
                return 8'(r);
            end
        endcase
    endfunction

    function automatic string req_of(int mode);
        case (mode)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5/R6";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_req(int mode, logic [127:0] t, logic [127:0] l, logic [7:0] cr);
        logic [127:0] exp_row;
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'(mode); top_i = t; left_i = l; corner_i = cr;
        @(negedge clk);
        chk(busy_o == 1'b1, "R10", "busy after accept", busy_o, 1);
        // junk request while busy: must be ignored (R7)
        start_i = 1'b1; mode_i = 2'($urandom); top_i = {$urandom, $urandom, $urandom, $urandom};
        left_i = {$urandom, $urandom, $urandom, $urandom}; corner_i = 8'($urandom);
        @(negedge clk);
        chk(row_valid_o == 1'b0, "R8", "no row in setup", row_valid_o, 0);
        for (int r = 0; r < 16; r++) begin
            if (r == 14) start_i = 1'b0;
            @(negedge clk);
            for (int x = 0; x < 16; x++) exp_row[8*x +: 8] = exp_pix(mode, t, l, cr, x, r);
            chk(row_valid_o == 1'b1 && row_idx_o == 4'(r), "R8", "row valid/index",
                {row_valid_o, row_idx_o}, {1'b1, 4'(r)});
            chk(done_o == (r == 15), "R8", "done flag", done_o, (r == 15));
            chk(row_o == exp_row, (r == 0) ? "R9" : req_of(mode), "row data (also R7)",
                row_o[63:0], exp_row[63:0]);
            if (r < 15) chk(busy_o == 1'b1, "R10", "busy during rows", busy_o, 1);
        end
        @(negedge clk);
        chk(row_valid_o == 1'b0 && busy_o == 1'b0, "R10", "idle after last row",
            {row_valid_o, busy_o}, 0);
    endtask

    initial begin
        logic [127:0] t, l;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && row_valid_o == 0 && done_o == 0, "R1", "reset outputs",
            {busy_o, row_valid_o, done_o}, 0);
        rst_n = 1'b1;
        // directed: column ordering and uniform fills
        for (int k = 0; k < 16; k++) begin
            t[8*k +: 8] = 8'(k * 16 + 1);
            l[8*k +: 8] = 8'(200 - k * 9);
        end
        run_req(0, t, l, 8'h40);
        run_req(1, t, l, 8'h40);
        run_req(2, t, l, 8'h40);
        run_req(2, {16{8'hff}}, {16{8'hff}}, 8'hff);
        run_req(3, {16{8'h00}}, {16{8'h00}}, 8'h00);
        // steep gradients forcing both clamps (R6)
        for (int k = 0; k < 16; k++) begin
            t[8*k +: 8] = 8'(k * 17);
            l[8*k +: 8] = 8'(k * 17);
        end
        run_req(3, t, l, 8'h00);
        for (int k = 0; k < 16; k++) begin
            t[8*k +: 8] = 8'(255 - k * 17);
            l[8*k +: 8] = 8'(k * 17);
        end
        run_req(3, t, l, 8'hff);
        run_req(3, {16{8'hff}}, {16{8'h00}}, 8'h80);
        // random requests, every mode
        for (int i = 0; i < 40; i++) begin
            run_req(i % 4, {$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom, $urandom}, 8'($urandom));
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule